// File: doc/BRIEF.md
# Mid-Packet Halfword Stripping Realigner

This block sits in a receive path between a serial-link packet receiver and a user-facing pass-through stream. Both sides carry 64-bit beats with valid, ready, start and end markers, a 3-bit empty count and an error flag. For long packets, it deletes the single 16-bit check field that the link inserts at byte offsets 80 and 81. It then moves every later halfword up by 16 bits so that the output stays densely packed, and it fixes the end-of-packet empty count. Short packets, the final check field and any alignment pad go through as ordinary data. The block does not check, generate or decode anything.

Both ports follow a ready latency of one cycle. A side may present a beat in a cycle only if its partner held ready high in the previous cycle, and every beat presented in that way is taken. The block holds at most three halfwords of residue between beats. When a packet's tail cannot fit into the beat that carries the input end marker, the block emits one extra beat. To make room for that beat it drops `in_ready` one cycle early, and it keeps `in_ready` low while `out_ready` is low.

Top module: `hw_strip_realign`

## Requirements
- R1: `out_valid` is high only in a cycle that follows a cycle with `out_ready` high. `in_ready` is low in every cycle where `out_ready` is low. An input beat is presented only in a cycle after `in_ready` was high, and it is always consumed.
- R2: A packet of 82 bytes or fewer is forwarded unchanged: the same bytes, the same beat boundaries and the same empty value.
- R3: A packet longer than 82 bytes leaves with the halfword at byte offsets 80..81 removed (offsets counted from the first byte of the start beat). All later bytes move up by two byte positions. Bytes run most significant first, and byte 0 of a beat is bits [63:56]. The final check field and the pad stay in place.
- R4: For a stripped packet whose last input beat carries only one halfword (input empty 6), the output ends one beat earlier with empty 0. Otherwise the end beat carries the input empty value plus 2. Any output beat that is produced without an input beat in the same cycle is an end-of-packet beat.
- R5: `out_empty` counts the unused bytes at the low end of the end beat. It is always even, and it is 0 on beats that are not end beats.
- R6: `out_error` is high only on an end beat. It is high there exactly when any input beat of that packet had `in_error` set.
- R7: `out_sop` is high on the first output beat of each packet and on no other beat.
- R8: A start beat that arrives while a previous packet never ended discards that packet's held residue, its error state and its beat position. The new packet is then processed exactly as if it had followed an idle link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat in the next cycle |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 3 | Unused low bytes on the last beat |
| in_error | input | 1 | Beat flagged in error |
| in_data | input | 64 | Beat bytes, first byte in [63:56] |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Sink can take a beat in the next cycle |
| out_sop | output | 1 | First output beat of a packet |
| out_eop | output | 1 | Last output beat of a packet |
| out_empty | output | 3 | Unused low bytes on the last beat |
| out_error | output | 1 | Packet had an error, shown on its last beat |
| out_data | output | 64 | Realigned beat bytes |

## Verification
The hardest case to reach is the extra tail beat: the input end beat arrives while three halfwords are already held, and the sink then stalls, so the tail has to wait while the input is held off. The stimulus sweeps every even packet length from 2 to 136 bytes twice, once under light back-pressure and once under heavy back-pressure. This puts the end beat at every halfword lane on both sides of the cut. An unterminated 96-byte packet, with an error on one beat, is followed directly by a new start beat to exercise the residue discard.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  localparam int HW_W = 16;
  typedef logic [HW_W-1:0] hw_t;

  // halfwords carried by a beat with the given number of valid bytes
  function automatic int hw_of_bytes(int nbytes);
    return (nbytes + 1) / 2;
  endfunction
endpackage

// File: rtl/hsr_pos.sv
module hsr_pos
  import hsr_pkg::*;
#(
  parameter int HWB        = 4,
  parameter int BEAT_BYTES = 8,
  parameter int CUT_OFS    = 80,
  parameter int CNT_W      = 3,
  parameter int LANE_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              sop,
  input  logic              eop,
  input  logic [CNT_W-1:0]  n_in,
  output logic              drop,
  output logic [LANE_W-1:0] lane
);
  localparam int CUT_BEAT = CUT_OFS / BEAT_BYTES;
  localparam int CUT_LANE = (CUT_OFS % BEAT_BYTES) / 2;
  localparam int BC_W     = $clog2(CUT_BEAT + 2);
  localparam int BC_MAX   = CUT_BEAT + 1;

  logic [BC_W-1:0] bcnt_q;
  logic [BC_W-1:0] idx;
  logic            at_cut;
  logic            more_follows;

  always_comb begin
    idx          = sop ? '0 : bcnt_q;
    at_cut       = (idx == BC_W'(CUT_BEAT));
    // the cut halfword is only removed when something comes after it
    more_follows = !eop || (int'(n_in) > CUT_LANE + 1);
    drop         = take && at_cut && more_follows;
    lane         = LANE_W'(CUT_LANE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
    end else if (take) begin
      bcnt_q <= (idx == BC_W'(BC_MAX)) ? idx : idx + 1'b1;
    end
  end
endmodule

// File: rtl/hsr_pack.sv
module hsr_pack
  import hsr_pkg::*;
#(
  parameter int HWB    = 4,
  parameter int CNT_W  = 3,
  parameter int LANE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               sop,
  input  logic               eop,
  input  logic               drop,
  input  logic [LANE_W-1:0]  lane,
  input  logic [CNT_W-1:0]   n_in,
  input  logic [HWB*HW_W-1:0] hw_in,
  input  logic               flush_ok,
  output logic               fire,
  output logic               last,
  output logic [CNT_W-1:0]   o_cnt,
  output logic [HWB*HW_W-1:0] o_data,
  output logic               flush_nxt
);
  localparam int SLOTS = 2 * HWB - 1;
  localparam int HOLD  = HWB - 1;

  hw_t             h     [HWB];
  hw_t             comp  [HWB];
  hw_t             slot  [SLOTS];
  hw_t             carry_q [HOLD];
  hw_t             carry_d [HOLD];
  hw_t             o_hw  [HWB];
  logic [CNT_W-1:0] cnt_q, cnt_d, c_eff, k, total;
  logic            flush_q, flush_d;
  logic            use_carry, shift;

  // split, drop one lane, and append behind the held residue
  always_comb begin
    for (int i = 0; i < HWB; i++) begin
      h[i] = hw_in[HWB*HW_W-1-HW_W*i -: HW_W];
    end
    for (int i = 0; i < HWB; i++) begin
      comp[i] = h[i];
      if (drop && i >= int'(lane)) begin
        comp[i] = (i + 1 < HWB) ? h[(i+1)%HWB] : '0;
      end
    end
    k     = n_in - CNT_W'(drop);
    c_eff = sop ? '0 : cnt_q;
    total = c_eff + k;
    for (int j = 0; j < SLOTS; j++) begin
      slot[j] = '0;
      for (int m = 0; m < HOLD; m++) begin
        if (m == j && CNT_W'(m) < c_eff) slot[j] = carry_q[m];
      end
      for (int m = 0; m < HWB; m++) begin
        if (m + int'(c_eff) == j && CNT_W'(m) < k) slot[j] = comp[m];
      end
    end
  end

  // emit decision and residue update
  always_comb begin
    fire      = 1'b0;
    last      = 1'b0;
    o_cnt     = '0;
    cnt_d     = cnt_q;
    flush_d   = flush_q;
    use_carry = 1'b0;
    shift     = 1'b0;
    if (flush_q) begin
      if (flush_ok) begin
        fire      = 1'b1;
        last      = 1'b1;
        o_cnt     = cnt_q;
        use_carry = 1'b1;
        flush_d   = 1'b0;
        cnt_d     = '0;
      end
    end else if (take) begin
      if (eop && total <= CNT_W'(HWB)) begin
        fire  = 1'b1;
        last  = 1'b1;
        o_cnt = total;
        cnt_d = '0;
      end else if (total >= CNT_W'(HWB)) begin
        fire    = 1'b1;
        o_cnt   = CNT_W'(HWB);
        cnt_d   = total - CNT_W'(HWB);
        shift   = 1'b1;
        flush_d = eop;
      end else begin
        cnt_d = total;
      end
    end
    for (int m = 0; m < HOLD; m++) begin
      if (shift)            carry_d[m] = slot[m+HWB];
      else if (take && !fire) carry_d[m] = slot[m];
      else                  carry_d[m] = carry_q[m];
    end
    for (int j = 0; j < HWB; j++) begin
      if (use_carry) begin
        o_hw[j] = (j < HOLD && CNT_W'(j) < cnt_q) ? carry_q[j%HOLD] : '0;
      end else begin
        o_hw[j] = (CNT_W'(j) < o_cnt) ? slot[j] : '0;
      end
      o_data[HWB*HW_W-1-HW_W*j -: HW_W] = o_hw[j];
    end
    flush_nxt = flush_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flush_q <= 1'b0;
      for (int m = 0; m < HOLD; m++) carry_q[m] <= '0;
    end else begin
      cnt_q   <= cnt_d;
      flush_q <= flush_d;
      for (int m = 0; m < HOLD; m++) carry_q[m] <= carry_d[m];
    end
  end
endmodule

// File: rtl/hw_strip_realign.sv
module hw_strip_realign
  import hsr_pkg::*;
#(
  parameter  int DATA_W  = 64,
  parameter  int CUT_OFS = 80,
  localparam int EMPTY_W = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [EMPTY_W-1:0] in_empty,
  input  logic              in_error,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic              out_eop,
  output logic [EMPTY_W-1:0] out_empty,
  output logic              out_error,
  output logic [DATA_W-1:0] out_data
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int HWB        = DATA_W / HW_W;
  localparam int CNT_W      = $clog2(2 * HWB);
  localparam int LANE_W     = $clog2(HWB);

  logic              rdy_q;
  logic              take;
  logic [CNT_W-1:0]  n_in;
  logic              drop;
  logic [LANE_W-1:0] lane;
  logic              fire, last, flush_nxt;
  logic [CNT_W-1:0]  o_cnt;
  logic              sop_pend_q, sop_pend_d;
  logic              err_q, err_cur;

  assign take = in_valid;

  always_comb begin
    if (in_eop) n_in = CNT_W'(hw_of_bytes(BEAT_BYTES - int'(in_empty)));
    else        n_in = CNT_W'(HWB);
  end

  hsr_pos #(
    .HWB(HWB), .BEAT_BYTES(BEAT_BYTES), .CUT_OFS(CUT_OFS),
    .CNT_W(CNT_W), .LANE_W(LANE_W)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .take(take), .sop(in_sop), .eop(in_eop),
    .n_in(n_in), .drop(drop), .lane(lane)
  );

  hsr_pack #(.HWB(HWB), .CNT_W(CNT_W), .LANE_W(LANE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .sop(in_sop), .eop(in_eop),
    .drop(drop), .lane(lane), .n_in(n_in), .hw_in(in_data),
    .flush_ok(rdy_q), .fire(fire), .last(last), .o_cnt(o_cnt),
    .o_data(out_data), .flush_nxt(flush_nxt)
  );

  // hold the source off for the cycle a tail beat will occupy
  assign in_ready = out_ready && !flush_nxt;

  always_comb begin
    out_valid = fire;
    out_eop   = last;
    out_sop   = fire && ((take && in_sop) || sop_pend_q);
    out_empty = last ? EMPTY_W'(2 * (HWB - int'(o_cnt))) : '0;
    err_cur   = (take && in_error) || (err_q && !(take && in_sop));
    out_error = last && err_cur;
    if (take && in_sop) sop_pend_d = !fire;
    else if (fire)      sop_pend_d = 1'b0;
    else                sop_pend_d = sop_pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q      <= 1'b0;
      sop_pend_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      rdy_q      <= out_ready;
      sop_pend_q <= sop_pend_d;
      err_q      <= (fire && last) ? 1'b0 : err_cur;
    end
  end
endmodule

// File: rtl/hsr_chk.sv
module hsr_chk #(
  parameter int EMPTY_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_ready,
  input logic              out_valid,
  input logic              out_eop,
  input logic              out_error,
  input logic [EMPTY_W-1:0] out_empty
);
  logic rdy_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_seen <= 1'b0;
    else        rdy_seen <= out_ready;
  end

  AST_OUT_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rdy_seen); // R1
  AST_READY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready); // R1
  AST_MID_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eop) |-> (out_empty == '0)); // R5
  AST_END_EMPTY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eop) |-> !out_empty[0]); // R5
  AST_ERROR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    out_error |-> (out_valid && out_eop)); // R6
  AST_EXTRA_BEAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |-> out_eop); // R4
endmodule

bind hw_strip_realign hsr_chk #(.EMPTY_W(EMPTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_ready(out_ready), .out_valid(out_valid), .out_eop(out_eop),
  .out_error(out_error), .out_empty(out_empty)
);

// File: tb/tb_hw_strip_realign.sv
`timescale 1ns/1ps
module tb_hw_strip_realign;
  localparam int WDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_error = 1'b0;
  logic [2:0]  in_empty = '0;
  logic [63:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, out_sop, out_eop, out_error;
  logic [2:0]  out_empty;
  logic [63:0] out_data;

  always #2 clk = ~clk;

  hw_strip_realign dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty), .in_error(in_error),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty),
    .out_error(out_error), .out_data(out_data)
  );

  typedef struct {
    logic [63:0] d;
    bit          sop, eop, err;
    logic [2:0]  emp;
    string       tag;
  } beat_t;

  beat_t in_q[$];
  beat_t exp_q[$];
  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit wd_hit = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bv(int len, int i);
    return 8'((len * 3 + i * 5 + 1) & 255);
  endfunction

  task automatic add_pkt(int len, bit has_eop, int err_beat, string tag);
    logic [7:0] s[$];
    int nb = (len + 7) / 8;
    int ns, nbo;
    bit strip;
    for (int b = 0; b < nb; b++) begin
      beat_t x;
      x.d = '0;
      for (int j = 0; j < 8; j++)
        if (b * 8 + j < len) x.d[63-8*j -: 8] = bv(len, b * 8 + j);
      x.sop = (b == 0);
      x.eop = has_eop && (b == nb - 1);
      x.emp = x.eop ? 3'(nb * 8 - len) : 3'd0;
      x.err = (b == err_beat);
      x.tag = tag;
      in_q.push_back(x);
    end
    // R3: the halfword at offsets 80..81 goes only if more bytes follow it
    strip = has_eop ? (len > 82) : (len > 81);
    for (int i = 0; i < len; i++)
      if (!(strip && (i == 80 || i == 81))) s.push_back(bv(len, i));
    ns  = s.size();
    nbo = has_eop ? (ns + 7) / 8 : ns / 8;
    for (int b = 0; b < nbo; b++) begin
      beat_t x;
      x.d = '0;
      for (int j = 0; j < 8; j++)
        if (b * 8 + j < ns) x.d[63-8*j -: 8] = s[b*8+j];
      x.sop = (b == 0);
      x.eop = has_eop && (b == nbo - 1);
      x.emp = x.eop ? 3'(nbo * 8 - ns) : 3'd0;
      x.err = x.eop && (err_beat >= 0);
      x.tag = tag;
      exp_q.push_back(x);
    end
  endtask

  task automatic check_beat();
    beat_t e;
    int nv;
    logic [63:0] mask;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R3", "unexpected output beat", out_data, 64'h0);
      return;
    end
    e = exp_q.pop_front();
    nv = e.eop ? 8 - int'(e.emp) : 8;
    mask = {64{1'b1}} << (64 - 8 * nv);
    chk((out_data & mask) == (e.d & mask), e.tag, "data", out_data & mask, e.d & mask);
    chk(out_sop == e.sop, "R7", "sop", 64'(out_sop), 64'(e.sop));
    chk(out_eop == e.eop, "R4", "eop position", 64'(out_eop), 64'(e.eop));
    chk(out_empty == e.emp, e.eop ? "R4" : "R5", "empty", 64'(out_empty), 64'(e.emp));
    chk(out_error == e.err, "R6", "error", 64'(out_error), 64'(e.err));
  endtask

  task automatic run(int ready_pct);
    bit prev_in_rdy = 0;
    bit prev_out_rdy = 0;
    while ((in_q.size() > 0 || exp_q.size() > 0) && !wd_hit) begin
      @(negedge clk);
      cyc++;
      if (cyc >= WDOG) wd_hit = 1;
      out_ready = ($urandom_range(0, 99) < ready_pct);
      if (prev_in_rdy && in_q.size() > 0 && $urandom_range(0, 99) < 85) begin
        beat_t x = in_q.pop_front();
        in_valid = 1'b1; in_data = x.d; in_sop = x.sop; in_eop = x.eop;
        in_empty = x.emp; in_error = x.err;
      end else begin
        in_valid = 1'b0; in_data = '0; in_sop = 1'b0; in_eop = 1'b0;
        in_empty = '0; in_error = 1'b0;
      end
      #1;
      if (out_valid) begin
        chk(prev_out_rdy, "R1", "valid without prior ready", 64'(out_valid), 64'(0));
        check_beat();
      end
      if (!out_ready)
        chk(!in_ready, "R1", "in_ready while out_ready low", 64'(in_ready), 64'(0));
      prev_in_rdy  = in_ready;
      prev_out_rdy = out_ready;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_error = 1'b0;
  endtask

  task automatic sweep(int ready_pct);
    for (int len = 2; len <= 136; len += 2) begin
      int eb = (len % 3 == 0) ? ((len + 7) / 8) / 2 : -1;
      add_pkt(len, 1'b1, eb, (len <= 82) ? "R2" : "R3");
    end
    // R8: unterminated packet holding residue, then a fresh start
    add_pkt(96, 1'b0, 2, "R8");
    add_pkt(120, 1'b1, -1, "R8");
    run(ready_pct);
  endtask

  initial begin
    out_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1;
      chk(!out_valid, "R1", "valid during reset", 64'(out_valid), 64'(0));
    end
    rst_n = 1'b1;
    sweep(80);
    if (!wd_hit) sweep(35);
    if (!wd_hit) begin
      // R2 R3 R4: the named lengths again with full throughput
      add_pkt(40, 1'b1, -1, "R2");
      add_pkt(80, 1'b1, 1, "R2");
      add_pkt(82, 1'b1, -1, "R2");
      add_pkt(120, 1'b1, 14, "R3");
      run(100);
    end
    if (wd_hit) chk(1'b0, "R1", "watchdog expired", 64'(cyc), 64'(WDOG));
    chk(exp_q.size() == 0, "R3", "missing output beats", 64'(exp_q.size()), 64'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule